// File: doc/BRIEF.md
# Periodic Clock Register File

This block is a small bank of clock registers that a host reaches through two ports: an index port and a data port. The host first loads a register index through the index port, then reads or writes the selected register through the data port. Indices 0x00 to 0x09 are ten plain time-of-day bytes that the host loads and reads back; the block does no calendar arithmetic on them. Index 0x0A is a rate/status register, 0x0B is a control register, and 0x0C and 0x0D are status registers that always read zero.

The rate/status register carries an update-in-progress flag in bit 7, and every read of it inverts that flag. The control register holds the periodic-interrupt enable. While that enable is set, a tick machine with the states HALT, COUNT and FIRE pulses the interrupt output for one cycle every PERIOD clock cycles. HALT goes to COUNT when the enable is set. COUNT goes to FIRE when its cycle count reaches PERIOD-1. FIRE goes back to COUNT. COUNT and FIRE both go to HALT when the enable is cleared. The interrupt output is high only in FIRE.

Top module: `rtc_regfile`

## Requirements
- R1: After reset the selected index is 0x00, every time byte is 0x00, register 0x0A holds 0x26 (bit 7 flag clear, bits 6:4 = 010 for the 32.768 kHz base, bits 3:0 = 0110 for 1024 Hz), register 0x0B holds 0x46 (bit 6 enable, bit 2 binary, bit 1 24-hour), and irq is low.
- R2: A write on the index port (addr_we) with wdata at most 0x0D selects that index from the next cycle. A larger value is ignored and the previous index stays selected.
- R3: Indices 0x00 to 0x09 are byte storage: data_we stores wdata, and data_re returns the stored byte. Read data appears on rd_data in the cycle after the read strobe and holds until the next read.
- R4: Each read of 0x0A inverts bit 7 of that register and returns the inverted value. The first read after reset returns 0xA6 and the second returns 0x26.
- R5: Indices 0x0C and 0x0D always read 0x00, and writes to them have no effect.
- R6: A write to 0x0A is accepted only when the value is exactly 0x26, which also clears the bit 7 flag. Any other value is ignored.
- R7: A write to 0x0B is accepted only if bits 2 and 1 are set and bits 7, 5, 4 and 0 are clear. Only bit 6 (periodic enable) and bit 3 (square-wave enable) can change. A write that breaks this rule is ignored.
- R8: While bit 6 of 0x0B is set, irq is a one-cycle pulse, and consecutive pulses are exactly PERIOD cycles apart.
- R9: Clearing bit 6 stops the pulses. At most one pulse can still appear, in the cycle right after the write edge. Setting bit 6 again from clear produces the first pulse PERIOD cycles after the write edge.
- R10: Writing 0x0B with bit 6 set while it is already set does not restart the interval: the next pulse keeps the PERIOD spacing from the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_we | input | 1 | Load wdata as the register index |
| data_we | input | 1 | Write wdata to the selected register |
| data_re | input | 1 | Read the selected register |
| wdata | input | 8 | Write data for both ports |
| rd_data | output | 8 | Read result, registered |
| irq | output | 1 | Periodic interrupt pulse |

## Verification
The checker assumes that data_we and data_re are never asserted in the same cycle, and that a data access uses the index already selected, not one loaded in the same cycle. The directed tasks drive one strobe per cycle on falling edges, so both assumptions always hold. The interrupt timing checks count cycles from the write edge and from the previous pulse, so they are not tied to any absolute cycle after reset.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int IDX_W = 4;
    localparam int DATA_W = 8;
    localparam logic [IDX_W-1:0] IDX_RATE = 4'hA;
    localparam logic [IDX_W-1:0] IDX_CTRL = 4'hB;
    localparam logic [IDX_W-1:0] IDX_LAST = 4'hD;
    localparam int TIME_BYTES = 10;
    localparam logic [DATA_W-1:0] RATE_INIT = 8'h26;
    localparam logic [DATA_W-1:0] CTRL_INIT = 8'h46;
    localparam logic [DATA_W-1:0] FLAG_MASK = 8'h80;
    localparam logic [DATA_W-1:0] CTRL_FREE = 8'h48;
    localparam logic [DATA_W-1:0] CTRL_FIXED = 8'h06;
    localparam int EN_BIT = 6;

    typedef enum logic [1:0] {
        TK_HALT  = 2'd0,
        TK_COUNT = 2'd1,
        TK_FIRE  = 2'd2
    } tick_state_t;
endpackage

// File: rtl/rtc_index_port.sv
module rtc_index_port
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [IDX_W-1:0]  idx
);
    logic in_range;

    always_comb begin
        in_range = (wdata <= DATA_W'(IDX_LAST));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (addr_we && in_range) begin
            idx <= wdata[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] rate_q,
    output logic [DATA_W-1:0] ctrl_q
);
    logic [DATA_W-1:0] time_w [TIME_BYTES];
    logic [DATA_W-1:0] read_val;
    logic              rate_ok;
    logic              ctrl_ok;

    for (genvar g = 0; g < TIME_BYTES; g++) begin : g_time
        logic [DATA_W-1:0] byte_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (data_we && idx == IDX_W'(g)) begin
                byte_q <= wdata;
            end
        end
        assign time_w[g] = byte_q;
    end

    always_comb begin
        rate_ok = (wdata == RATE_INIT);
        ctrl_ok = ((wdata & ~CTRL_FREE) == CTRL_FIXED);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= RATE_INIT;
        end else if (data_we && idx == IDX_RATE) begin
            if (rate_ok) begin
                rate_q <= wdata;
            end
        end else if (data_re && idx == IDX_RATE) begin
            rate_q <= rate_q ^ FLAG_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_INIT;
        end else if (data_we && idx == IDX_CTRL && ctrl_ok) begin
            ctrl_q <= wdata;
        end
    end

    always_comb begin
        if (idx < IDX_RATE) begin
            read_val = time_w[idx];
        end else if (idx == IDX_RATE) begin
            read_val = rate_q ^ FLAG_MASK;
        end else if (idx == IDX_CTRL) begin
            read_val = ctrl_q;
        end else begin
            read_val = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (data_re) begin
            rd_data <= read_val;
        end
    end
endmodule

// File: rtl/rtc_tick_fsm.sv
module rtc_tick_fsm
    import rtc_pkg::*;
#(
    parameter int PERIOD = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic pulse
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
    localparam logic [CW-1:0] FIRST = CW'(1);

    tick_state_t       state_q, state_d;
    logic [CW-1:0]     cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TK_HALT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TK_HALT: begin
                if (run) begin
                    state_d = TK_COUNT;
                    cnt_d   = FIRST;
                end
            end
            TK_COUNT: begin
                if (!run) begin
                    state_d = TK_HALT;
                end else if (cnt_q == LAST) begin
                    state_d = TK_FIRE;
                end else begin
                    cnt_d = cnt_q + FIRST;
                end
            end
            TK_FIRE: begin
                if (!run) begin
                    state_d = TK_HALT;
                end else begin
                    state_d = TK_COUNT;
                    cnt_d   = FIRST;
                end
            end
            default: begin
                state_d = TK_HALT;
            end
        endcase
    end

    always_comb begin
        pulse = (state_q == TK_FIRE);
    end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int PERIOD = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic [IDX_W-1:0]  cur_idx;
    logic [DATA_W-1:0] rate_val;
    logic [DATA_W-1:0] ctrl_val;
    logic              tick_run;

    rtc_index_port u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_we (addr_we),
        .wdata   (wdata),
        .idx     (cur_idx)
    );

    rtc_regbank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (cur_idx),
        .data_we (data_we),
        .data_re (data_re),
        .wdata   (wdata),
        .rd_data (rd_data),
        .rate_q  (rate_val),
        .ctrl_q  (ctrl_val)
    );

    assign tick_run = ctrl_val[EN_BIT];

    rtc_tick_fsm #(.PERIOD(PERIOD)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tick_run),
        .pulse (irq)
    );
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              addr_we,
    input logic              data_re,
    input logic [DATA_W-1:0] wdata,
    input logic [IDX_W-1:0]  cur_idx,
    input logic [DATA_W-1:0] rate_val,
    input logic [DATA_W-1:0] ctrl_val,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq
);
    a_r2_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        cur_idx <= IDX_LAST);

    a_r2_bad_index_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_we && wdata > DATA_W'(IDX_LAST)) |=> $stable(cur_idx));

    a_r4_flag_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (data_re && cur_idx == IDX_RATE) |=> (rd_data[7] != $past(rate_val[7])));

    a_r5_cd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (data_re && cur_idx > IDX_CTRL) |=> (rd_data == '0));

    a_r7_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_val & ~CTRL_FREE) == CTRL_FIXED);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_val[EN_BIT] && $past(!ctrl_val[EN_BIT])) |-> !irq);
endmodule

bind rtc_regfile rtc_regfile_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_we  (addr_we),
    .data_re  (data_re),
    .wdata    (wdata),
    .cur_idx  (cur_idx),
    .rate_val (rate_val),
    .ctrl_val (ctrl_val),
    .rd_data  (rd_data),
    .irq      (irq)
);

// File: tb/test_rtc_regfile.sv
module test_rtc_regfile;
    localparam int PERIOD = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_we = 1'b0;
    logic       data_we = 1'b0;
    logic       data_re = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rd_data;
    logic       irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int irq_cnt = 0;
    int last_cyc = 0;
    int last_gap = 0;
    bit done = 1'b0;

    rtc_regfile #(.PERIOD(PERIOD)) i_rtc_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_we (addr_we),
        .data_we (data_we),
        .data_re (data_re),
        .wdata   (wdata),
        .rd_data (rd_data),
        .irq     (irq)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && irq) begin
            last_gap = cyc - last_cyc;
            last_cyc = cyc;
            irq_cnt  = irq_cnt + 1;
        end
    end

    task automatic check(input int act, input int exp, input string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic put_index(input logic [7:0] v);
        @(negedge clk);
        addr_we = 1'b1; wdata = v;
        @(negedge clk);
        addr_we = 1'b0;
    endtask

    task automatic put_data(input logic [7:0] v);
        @(negedge clk);
        data_we = 1'b1; wdata = v;
        @(negedge clk);
        data_we = 1'b0;
    endtask

    task automatic get_data(output logic [7:0] v);
        @(negedge clk);
        data_re = 1'b1;
        @(negedge clk);
        data_re = 1'b0;
        v = rd_data;
    endtask

    task automatic wait_pulse(output bit seen);
        int start;
        start = irq_cnt;
        seen = 1'b0;
        for (int k = 0; k < 4 * PERIOD; k++) begin
            @(negedge clk);
            if (irq_cnt != start) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check(irq, 0, "R1 irq low");
        get_data(v);
        check(v, 8'h00, "R1 index 0 time byte");
        put_index(8'h0B);
        get_data(v);
        check(v, 8'h46, "R1 control init");
        put_index(8'h0A);
        get_data(v);
        check(v, 8'hA6, "R4 first rate read");
        get_data(v);
        check(v, 8'h26, "R4 second rate read");
    endtask

    task automatic t_time();
        logic [7:0] v;
        for (int i = 0; i < 10; i++) begin
            put_index(8'(i));
            put_data(8'(8'h11 * i + 3));
        end
        for (int i = 9; i >= 0; i--) begin
            put_index(8'(i));
            get_data(v);
            check(v, 8'(8'h11 * i + 3), "R3 time byte");
        end
        repeat (3) @(negedge clk);
        check(rd_data, 8'h03, "R3 read data held");
    endtask

    task automatic t_index();
        logic [7:0] v;
        put_index(8'h05);
        put_index(8'h0E);
        get_data(v);
        check(v, 8'h58, "R2 index 0x0E rejected");
        put_index(8'hFF);
        get_data(v);
        check(v, 8'h58, "R2 index 0xFF rejected");
        put_index(8'h0D);
        get_data(v);
        check(v, 8'h00, "R2 index 0x0D accepted");
    endtask

    task automatic t_cd();
        logic [7:0] v;
        put_index(8'h0C);
        put_data(8'h5A);
        get_data(v);
        check(v, 8'h00, "R5 reg C reads zero");
        put_index(8'h0D);
        put_data(8'hFF);
        get_data(v);
        check(v, 8'h00, "R5 reg D reads zero");
        put_index(8'h0B);
        get_data(v);
        check(v, 8'h46, "R5 write to D left control alone");
    endtask

    task automatic t_rate();
        logic [7:0] v;
        put_index(8'h0A);
        put_data(8'h55);
        get_data(v);
        check(v, 8'hA6, "R6 bad rate write ignored");
        put_data(8'h26);
        get_data(v);
        check(v, 8'hA6, "R6 reset-value write accepted");
    endtask

    task automatic t_ctrl();
        logic [7:0] v;
        put_index(8'h0B);
        put_data(8'h40);
        get_data(v);
        check(v, 8'h46, "R7 missing fixed bits ignored");
        put_data(8'h4E);
        get_data(v);
        check(v, 8'h4E, "R7 square-wave bit accepted");
        put_data(8'hC6);
        get_data(v);
        check(v, 8'h4E, "R7 bit 7 write ignored");
        put_data(8'h46);
        get_data(v);
        check(v, 8'h46, "R7 restore");
    endtask

    task automatic t_period();
        bit seen;
        wait_pulse(seen);
        check(seen, 1, "R8 pulse seen");
        wait_pulse(seen);
        check(seen, 1, "R8 second pulse seen");
        check(last_gap, PERIOD, "R8 pulse spacing");
        @(negedge clk);
        check(irq, 0, "R8 pulse one cycle wide");
    endtask

    task automatic t_stop_start();
        bit seen;
        int snap;
        int wcyc;
        put_index(8'h0B);
        put_data(8'h06);
        @(negedge clk);
        snap = irq_cnt;
        repeat (3 * PERIOD) @(negedge clk);
        check(irq_cnt, snap, "R9 no pulses when disabled");
        put_data(8'h46);
        wcyc = cyc;
        wait_pulse(seen);
        check(seen, 1, "R9 restart pulse seen");
        check(last_cyc - wcyc, PERIOD, "R9 first pulse after enable");
    endtask

    task automatic t_rewrite();
        bit seen;
        wait_pulse(seen);
        repeat (4) @(negedge clk);
        put_data(8'h46);
        wait_pulse(seen);
        check(seen, 1, "R10 pulse after rewrite");
        check(last_gap, PERIOD, "R10 spacing kept on rewrite");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_time();
        t_index();
        t_cd();
        t_rate();
        t_ctrl();
        t_period();
        t_stop_start();
        t_rewrite();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule